// File: doc/BRIEF.md
# MSI Receive Interrupt Controller

This block sits on the inbound write path of a PCIe root port and turns message-signalled interrupt writes into a level interrupt for the host processor. Every inbound write (a 64-bit address with a 32-bit data word) is compared against a programmable 64-bit target address. On a hit, the data word is used directly as a vector number. If that vector is enabled, its pending bit is latched.

Vectors are grouped into banks of 32. Each bank has an enable word, a mask word and a pending-status word. Pending bits are cleared by writing a 1 to them. The single interrupt output is asserted while any pending bit is unmasked.

Software reaches the target address and the per-bank words through a plain single-cycle register port. Writes take effect on the clock edge where the write strobe is high. Reads are combinational on the address.

Top module: `msi_rx_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and `irq_o` is 0.
- R2: The target address is held as a low word at register offset 0x820 and a high word at offset 0x824. Both words read back what was written. An inbound write sets a pending bit only when its address equals the full 64-bit value {high word, low word}.
- R3: Vector n lives in bank n/32 at bit n%32. The message data word equals the vector number. Bank b has its enable word at offset 0x828+12·b, its mask word at 0x82C+12·b and its status word at 0x830+12·b. The enable and mask words read back as written.
- R4: A matching message for a vector whose enable bit is 0 leaves all status bits unchanged.
- R5: Writing the status word clears each bit written as 1 and leaves each bit written as 0 unchanged. A register write can never set a status bit. After a bit is cleared, a new matching message sets it again.
- R6: If a matching, enabled message and a status write that clears the same bit occur on the same clock edge, the bit ends up set.
- R7: `irq_o` is the OR over all banks of (status AND NOT mask). It is valid in the cycle after the edge that changed the status or mask. A masked pending bit stays latched, and `irq_o` rises when its mask bit is cleared.
- R8: A message whose 32-bit data value is equal to or above the number of implemented vectors (32 × NUM_BANKS) changes no state.
- R9: Reads from offsets that hold no register return 0. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msi_valid_i | input | 1 | Inbound write present this cycle |
| msi_addr_i | input | 64 | Inbound write address |
| msi_data_i | input | 32 | Inbound write data (vector number) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW (12) | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Combined interrupt toward the host |

## Verification
A corrupted enable, mask or status bit shows up at the ports in one of two ways. It appears in the cycle after the offending edge as a wrong `irq_o` level. It also appears at once on `reg_rdata_o` when the bank's words are read back.

A wrong address or range decision is caught on the next status read. That read shows either a bit that should not have latched or one that is missing. A wrong same-edge priority between set and clear is visible one cycle later, because the bit reads 0 instead of 1.

// File: rtl/msi_rx_pkg.sv
// Package: msi_rx_pkg
// Shared register map constants and an offset helper for the MSI receive
// controller. Assumes byte offsets and 32-bit registers.
package msi_rx_pkg;
    localparam int unsigned BANK_W      = 32;
    localparam int unsigned BIT_IDX_W   = 5;
    localparam int unsigned TGT_LO_OFS  = 'h820;
    localparam int unsigned TGT_HI_OFS  = 'h824;
    localparam int unsigned BANK0_OFS   = 'h828;
    localparam int unsigned BANK_STRIDE = 12;
    localparam int unsigned SLOT_ENA    = 0;
    localparam int unsigned SLOT_MSK    = 4;
    localparam int unsigned SLOT_STS    = 8;

    // Byte offset of one register slot of one bank.
    function automatic int unsigned bank_reg_ofs(input int unsigned b, input int unsigned slot);
        return BANK0_OFS + b * BANK_STRIDE + slot;
    endfunction
endpackage

// File: rtl/msi_target_regs.sv
// Module: msi_target_regs
// Holds the 64-bit message target address as two 32-bit words and flags
// inbound writes whose address matches it. Assumes the write strobes are
// already decoded to a single word each.
module msi_target_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo_i,
    input  logic        wr_hi_i,
    input  logic [31:0] wdata_i,
    input  logic [63:0] msi_addr_i,
    output logic [31:0] tgt_lo_o,
    output logic [31:0] tgt_hi_o,
    output logic        hit_o
);
    logic [31:0] lo_q;
    logic [31:0] hi_q;

    // Load the target words from register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (wr_lo_i) lo_q <= wdata_i;
            if (wr_hi_i) hi_q <= wdata_i;
        end
    end

    // Full 64-bit address compare against the stored target.
    always_comb hit_o = (msi_addr_i == {hi_q, lo_q});

    assign tgt_lo_o = lo_q;
    assign tgt_hi_o = hi_q;
endmodule

// File: rtl/msi_vec_bank.sv
// Module: msi_vec_bank
// One bank of 32 vectors: enable, mask and write-one-to-clear status words.
// A message set for this bank is applied after the clear, so a new message
// wins over a same-edge clear. Assumes set_vld_i is only high for this bank.
module msi_vec_bank (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ena_wr_i,
    input  logic        msk_wr_i,
    input  logic        sts_wr_i,
    input  logic [31:0] wdata_i,
    input  logic        set_vld_i,
    input  logic [4:0]  set_bit_i,
    output logic [31:0] ena_o,
    output logic [31:0] msk_o,
    output logic [31:0] sts_o,
    output logic        pend_o
);
    logic [31:0] ena_q;
    logic [31:0] msk_q;
    logic [31:0] sts_q;
    logic [31:0] set_vec;
    logic [31:0] clr_vec;

    // Decode the incoming vector into a one-hot set mask gated by enable.
    always_comb begin
        set_vec = '0;
        if (set_vld_i) set_vec = (32'd1 << set_bit_i) & ena_q;
        clr_vec = sts_wr_i ? wdata_i : 32'd0;
    end

    // Update enable, mask and status words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q <= '0;
            msk_q <= '0;
            sts_q <= '0;
        end else begin
            if (ena_wr_i) ena_q <= wdata_i;
            if (msk_wr_i) msk_q <= wdata_i;
            sts_q <= (sts_q & ~clr_vec) | set_vec;
        end
    end

    // Unmasked pending indication for this bank.
    always_comb pend_o = |(sts_q & ~msk_q);

    assign ena_o = ena_q;
    assign msk_o = msk_q;
    assign sts_o = sts_q;

    // R4
    set_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q & ~$past(sts_q) & ~$past(ena_q)) == 32'd0);

    // R5
    clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~sts_q & $past(sts_q)) != 32'd0) |-> $past(sts_wr_i));

    // R5
    no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(set_vld_i) |-> ((sts_q & ~$past(sts_q)) == 32'd0));
endmodule

// File: rtl/msi_rx_ctrl.sv
// Module: msi_rx_ctrl
// Top of the MSI receive controller. Decodes register offsets, matches
// inbound message writes against the target, routes the vector to its
// bank and combines the unmasked pending bits into irq_o.
// Assumes one inbound write and one register access per cycle at most.
module msi_rx_ctrl #(
    parameter int NUM_BANKS = 2,
    parameter int REG_AW    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_valid_i,
    input  logic [63:0]       msi_addr_i,
    input  logic [31:0]       msi_data_i,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o
);
    import msi_rx_pkg::*;

    localparam int NUM_VEC = NUM_BANKS * BANK_W;
    localparam int SEL_W   = 32 - BIT_IDX_W;

    logic        lo_sel, hi_sel, hit, vec_ok, take;
    logic [31:0] tgt_lo, tgt_hi;
    logic [NUM_BANKS-1:0] pend;
    logic [31:0] bank_rd [NUM_BANKS];
    logic [NUM_VEC-1:0] sts_all;

    // Target word selects.
    always_comb begin
        lo_sel = (reg_addr_i == REG_AW'(TGT_LO_OFS));
        hi_sel = (reg_addr_i == REG_AW'(TGT_HI_OFS));
    end

    msi_target_regs u_tgt (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_lo_i    (reg_wr_i && lo_sel),
        .wr_hi_i    (reg_wr_i && hi_sel),
        .wdata_i    (reg_wdata_i),
        .msi_addr_i (msi_addr_i),
        .tgt_lo_o   (tgt_lo),
        .tgt_hi_o   (tgt_hi),
        .hit_o      (hit)
    );

    // Accept a message only when it hits the target and names a real vector.
    always_comb begin
        vec_ok = (msi_data_i < 32'(NUM_VEC));
        take   = msi_valid_i && hit && vec_ok;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic        ena_sel, msk_sel, sts_sel, set_here;
        logic [31:0] ena_w, msk_w, sts_w;

        // Per-bank offset decode and vector routing.
        always_comb begin
            ena_sel  = (reg_addr_i == REG_AW'(bank_reg_ofs(b, SLOT_ENA)));
            msk_sel  = (reg_addr_i == REG_AW'(bank_reg_ofs(b, SLOT_MSK)));
            sts_sel  = (reg_addr_i == REG_AW'(bank_reg_ofs(b, SLOT_STS)));
            set_here = take && (msi_data_i[31:BIT_IDX_W] == SEL_W'(b));
        end

        msi_vec_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .ena_wr_i  (reg_wr_i && ena_sel),
            .msk_wr_i  (reg_wr_i && msk_sel),
            .sts_wr_i  (reg_wr_i && sts_sel),
            .wdata_i   (reg_wdata_i),
            .set_vld_i (set_here),
            .set_bit_i (msi_data_i[BIT_IDX_W-1:0]),
            .ena_o     (ena_w),
            .msk_o     (msk_w),
            .sts_o     (sts_w),
            .pend_o    (pend[b])
        );

        // Per-bank read data contribution, zero when not addressed.
        always_comb begin
            bank_rd[b] = ({32{ena_sel}} & ena_w) | ({32{msk_sel}} & msk_w) |
                         ({32{sts_sel}} & sts_w);
        end

        assign sts_all[b*BANK_W +: BANK_W] = sts_w;
    end

    // Read data merge across target words and banks.
    always_comb begin
        reg_rdata_o = ({32{lo_sel}} & tgt_lo) | ({32{hi_sel}} & tgt_hi);
        for (int b = 0; b < NUM_BANKS; b++) reg_rdata_o = reg_rdata_o | bank_rd[b];
    end

    // Combined interrupt.
    always_comb irq_o = |pend;

    // R2
    miss_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_valid_i && !hit && !reg_wr_i) |=> $stable(sts_all));

    // R8
    range_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_valid_i && !vec_ok && !reg_wr_i) |=> $stable(sts_all));

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(take) || $past(reg_wr_i)));
endmodule

// File: tb/sim_msi_rx_ctrl.sv
module sim_msi_rx_ctrl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        msi_valid = 0;
    logic [63:0] msi_addr = '0;
    logic [31:0] msi_data = '0;
    logic        reg_wr = 0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;

    localparam logic [63:0] TGT = 64'h0000_0001_1000_0040;

    always #5 clk = ~clk;

    msi_rx_ctrl #(.NUM_BANKS(2), .REG_AW(12)) u0 (
        .clk(clk), .rst_n(rst_n), .msi_valid_i(msi_valid), .msi_addr_i(msi_addr),
        .msi_data_i(msi_data), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic msi(input logic [63:0] a, input logic [31:0] d);
        @(negedge clk);
        msi_valid = 1; msi_addr = a; msi_data = d;
        @(negedge clk);
        msi_valid = 0;
        #1;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(12'h820, v); chk("R1 tgt lo", v, 0);
        rd(12'h824, v); chk("R1 tgt hi", v, 0);
        for (int a = 'h828; a <= 'h83C; a += 4) begin
            rd(12'(a), v); chk("R1 bank reg", v, 0);
        end
        chk("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_target;
        logic [31:0] v;
        wr(12'h820, TGT[31:0]);
        wr(12'h824, TGT[63:32]);
        rd(12'h820, v); chk("R2 lo readback", v, TGT[31:0]);
        rd(12'h824, v); chk("R2 hi readback", v, TGT[63:32]);
    endtask

    task automatic t_map_enable;
        logic [31:0] v;
        wr(12'h828, 32'h0000_0020);
        rd(12'h828, v); chk("R3 enable readback", v, 32'h20);
        msi(TGT, 5);
        rd(12'h830, v); chk("R3 bank0 bit5", v, 32'h20);
        chk("R7 irq after set", {31'd0, irq}, 1);
        msi(TGT, 37);
        rd(12'h83C, v); chk("R4 disabled vector ignored", v, 0);
        wr(12'h834, 32'hFFFF_FFFF);
        msi(TGT, 37);
        rd(12'h83C, v); chk("R3 bank1 bit5", v, 32'h20);
        rd(12'h830, v); chk("R3 bank0 untouched", v, 32'h20);
        wr(12'h830, 32'hFFFF_FFFF);
        wr(12'h83C, 32'hFFFF_FFFF);
        chk("R7 irq low after clears", {31'd0, irq}, 0);
    endtask

    task automatic t_addr_miss;
        logic [31:0] v;
        msi({TGT[63:32] ^ 32'h1, TGT[31:0]}, 37);
        rd(12'h83C, v); chk("R2 high word mismatch", v, 0);
        msi({TGT[63:32], TGT[31:0] ^ 32'h4}, 37);
        rd(12'h83C, v); chk("R2 low word mismatch", v, 0);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        msi(TGT, 33); msi(TGT, 40);
        rd(12'h83C, v); chk("R5 two set", v, 32'h0000_0102);
        wr(12'h83C, 32'h0);
        rd(12'h83C, v); chk("R5 zero write keeps", v, 32'h0000_0102);
        wr(12'h83C, 32'h0000_0002);
        rd(12'h83C, v); chk("R5 one bit cleared", v, 32'h0000_0100);
        wr(12'h83C, 32'h0000_00F0);
        rd(12'h83C, v); chk("R5 write cannot set", v, 32'h0000_0100);
        msi(TGT, 33);
        rd(12'h83C, v); chk("R5 re-arrival sets again", v, 32'h0000_0102);
        wr(12'h83C, 32'hFFFF_FFFF);
    endtask

    task automatic t_same_edge;
        logic [31:0] v;
        msi(TGT, 34);
        @(negedge clk);
        msi_valid = 1; msi_addr = TGT; msi_data = 34;
        reg_wr = 1; reg_addr = 12'h83C; reg_wdata = 32'h0000_0004;
        @(negedge clk);
        msi_valid = 0; reg_wr = 0;
        rd(12'h83C, v); chk("R6 set wins over clear", v, 32'h0000_0004);
        wr(12'h83C, 32'hFFFF_FFFF);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(12'h838, 32'h0000_0040);
        rd(12'h838, v); chk("R3 mask readback", v, 32'h40);
        msi(TGT, 38);
        rd(12'h83C, v); chk("R7 masked bit latched", v, 32'h40);
        chk("R7 masked irq low", {31'd0, irq}, 0);
        wr(12'h838, 32'h0);
        #1 chk("R7 irq on unmask", {31'd0, irq}, 1);
        wr(12'h83C, 32'h40);
    endtask

    task automatic t_range;
        logic [31:0] v;
        wr(12'h828, 32'hFFFF_FFFF);
        msi(TGT, 64);
        msi(TGT, 32'h8000_0005);
        msi(TGT, 32'h0000_0100);
        rd(12'h830, v); chk("R8 bank0 unchanged", v, 0);
        rd(12'h83C, v); chk("R8 bank1 unchanged", v, 0);
        chk("R8 irq low", {31'd0, irq}, 0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(12'h840, 32'hDEAD_BEEF);
        wr(12'h81C, 32'hDEAD_BEEF);
        rd(12'h840, v); chk("R9 unmapped read 840", v, 0);
        rd(12'h81C, v); chk("R9 unmapped read 81C", v, 0);
        rd(12'h820, v); chk("R9 target lo intact", v, TGT[31:0]);
        rd(12'h834, v); chk("R9 bank1 enable intact", v, 32'hFFFF_FFFF);
    endtask

    initial begin
        #1_000_000;
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_target();
        t_map_enable();
        t_addr_miss();
        t_w1c();
        t_same_edge();
        t_mask();
        t_range();
        t_unmapped();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule